// File: doc/BRIEF.md
# SPI Shift Exchange Engine

This block is the data path of a byte-wide SPI port that can act as master or as slave. Each transfer swaps one character. The engine sends its own byte on the serial output and takes in the partner's byte on the serial input at the same time. In master mode the shift and sample moments come as single-cycle strobes from an external clock generator. In slave mode the engine finds them itself by watching the synchronized incoming serial clock. In that mode the clock polarity and phase inputs choose which edge samples and which edge shifts.

Transmit has one buffer: a byte is written straight into the shifter and no second byte can wait behind it. Receive has two buffers. When a byte completes it moves into a parallel read buffer, so the shifter can take the next character at once. If a byte completes while the buffer still holds an unread byte, the engine raises an overrun flag. When a master transfer starts, the engine copies a slave-select pattern onto eight active-low select outputs and holds it there until the byte is done. The completion and overrun flags clear only through a read-buffer access followed by a status read.

Top module: `spi_xchg_engine`

## Requirements
- R1: A transfer exchanges exactly 8 bits, most significant bit first. Before the first sample, `sdo` shows bit 7 of the loaded byte. After each shift it shows the next lower bit. Each sampled `sdi` bit enters at the bottom of the shifter, so the first sampled bit ends up as bit 7 of the received byte.
- R2: `tx_load` is accepted only while `tx_ready` is 1. `tx_ready` is 0 for the whole of a master transfer and while a slave byte is partly shifted. A load attempted at those times changes neither the bits sent nor the transfer state.
- R3: On the 8th sample, the received byte is copied to `rx_data` and `done_flag` becomes 1 at the same clock edge. A master transfer ends there, so `xfer_active` returns to 0.
- R4: If a byte completes while the previous received byte has not been read with `rx_rd`, `ovr_flag` becomes 1. `rx_data` keeps the earlier, unread byte.
- R5: At a master start, `sel_out` takes the value of `sel_pattern`. It holds that value for the whole transfer even if `sel_pattern` changes. It is all ones whenever no master transfer is active.
- R6: When `master_en` is 0, the engine shifts on edges of `sck_in` only while `ssel_n_in` is low, and `shift_stb` and `sample_stb` have no effect. The leading edge is the first edge away from the idle level given by `cpol`. `cpha`=0 samples on leading edges and shifts on trailing edges; `cpha`=1 does the reverse.
- R7: A `stat_rd` pulse with no `rx_rd` since the previous `stat_rd` leaves both flags unchanged. An `rx_rd` followed later by a `stat_rd` clears `done_flag` and `ovr_flag` at the clock edge of that `stat_rd`.
- R8: `sdo_en` is 1 only during an active master transfer (master mode) or while the engine is selected (slave mode). Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = master mode, 0 = slave mode |
| cpol | input | 1 | Serial clock idle level (slave edge selection) |
| cpha | input | 1 | Serial clock phase (slave edge selection) |
| sample_stb | input | 1 | Master sample strobe from the clock generator |
| shift_stb | input | 1 | Master shift strobe from the clock generator |
| sck_in | input | 1 | Incoming serial clock in slave mode |
| ssel_n_in | input | 1 | Incoming active-low slave select |
| tx_data | input | 8 | Byte to transmit |
| tx_load | input | 1 | Write strobe for `tx_data` |
| tx_ready | output | 1 | Shifter can take a new byte |
| sel_pattern | input | 8 | Slave-select pattern applied at the next master start |
| sel_out | output | 8 | Active-low slave-select outputs |
| xfer_active | output | 1 | Master transfer in progress |
| sdi | input | 1 | Serial data input |
| sdo | output | 1 | Serial data output |
| sdo_en | output | 1 | Output enable for `sdo` |
| rx_data | output | 8 | Read buffer |
| rx_rd | input | 1 | Read-buffer access strobe |
| stat_rd | input | 1 | Status read strobe |
| done_flag | output | 1 | Transfer-complete flag |
| ovr_flag | output | 1 | Overrun flag |

## Verification
The hardest condition to reach is an overrun that has to leave the older byte intact. Getting there takes two complete master exchanges with no `rx_rd` between them, with different patterns on `sdi`, so that `rx_data` still showing the first pattern proves the second byte was dropped. The slave phase modes are just as hard to reach from the ports. The bench produces them by toggling `sck_in` with half-periods well above the synchronizer delay. It checks `sdo` just before each sampling edge, and it pulses the master strobes during the slave byte to show that they are ignored.

// File: rtl/spi_xchg_pkg.sv
package spi_xchg_pkg;
   typedef enum logic [1:0] {
      EDGE_NONE   = 2'b00,
      EDGE_LEAD   = 2'b01,
      EDGE_TRAIL  = 2'b10
   } edge_kind_e;

   function automatic logic [1:0] edge_role(input logic cpha_i, input logic lead_i, input logic trail_i);
      // returns {shift, sample}
      if (cpha_i) edge_role = {lead_i, trail_i};
      else        edge_role = {trail_i, lead_i};
   endfunction
endpackage

// File: rtl/spi_xchg_edge.sv
module spi_xchg_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cpol,
   input  logic cpha,
   input  logic sck_in,
   input  logic ssel_n_in,
   output logic selected,
   output logic sample_p,
   output logic shift_p
);
   import spi_xchg_pkg::*;

   logic sck_s, ssel_n_s, sck_prev;

   generate
      if (SYNC_STAGES < 1) begin : g_bad
         $error("SYNC_STAGES must be at least 1");
      end
      if (SYNC_STAGES == 1) begin : g_one
         logic sck_r, ssel_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_r  <= 1'b0;
               ssel_r <= 1'b1;
            end else begin
               sck_r  <= sck_in;
               ssel_r <= ssel_n_in;
            end
         end
         assign sck_s    = sck_r;
         assign ssel_n_s = ssel_r;
      end else begin : g_many
         logic [SYNC_STAGES-1:0] sck_r, ssel_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sck_r  <= '0;
               ssel_r <= '1;
            end else begin
               sck_r  <= {sck_r[SYNC_STAGES-2:0], sck_in};
               ssel_r <= {ssel_r[SYNC_STAGES-2:0], ssel_n_in};
            end
         end
         assign sck_s    = sck_r[SYNC_STAGES-1];
         assign ssel_n_s = ssel_r[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_s;
   end

   logic rise, fall, lead, trail;
   logic [1:0] role;
   assign rise     = sck_s & ~sck_prev;
   assign fall     = ~sck_s & sck_prev;
   assign lead     = cpol ? fall : rise;
   assign trail    = cpol ? rise : fall;
   assign selected = ~ssel_n_s;
   assign role     = edge_role(cpha, lead, trail);
   assign shift_p  = role[1] & selected;
   assign sample_p = role[0] & selected;
endmodule

// File: rtl/spi_xchg_shifter.sv
module spi_xchg_shifter #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              sample_p,
   input  logic              shift_p,
   input  logic              abort,
   input  logic              sdi,
   output logic              sdo,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] rx_word
);
   localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              out_bit;

   assign done    = sample_p && (cnt == LAST);
   assign rx_word = {sh[DATA_W-2:0], sdi};
   assign busy    = (cnt != '0);
   assign sdo     = out_bit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh      <= '0;
         cnt     <= '0;
         out_bit <= 1'b0;
      end else if (load) begin
         sh      <= load_val;
         cnt     <= '0;
         out_bit <= load_val[DATA_W-1];
      end else if (abort) begin
         cnt <= '0;
      end else begin
         if (sample_p) begin
            sh  <= rx_word;
            cnt <= done ? '0 : cnt + CNT_W'(1);
         end
         if (shift_p) out_bit <= sh[DATA_W-1];
      end
   end
endmodule

// File: rtl/spi_xchg_status.sv
module spi_xchg_status #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              done,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              rx_rd,
   input  logic              stat_rd,
   output logic [DATA_W-1:0] rx_data,
   output logic              done_flag,
   output logic              ovr_flag
);
   logic unread, armed, clr;

   assign clr = stat_rd & armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_data   <= '0;
         unread    <= 1'b0;
         armed     <= 1'b0;
         done_flag <= 1'b0;
         ovr_flag  <= 1'b0;
      end else begin
         if (rx_rd)        armed <= 1'b1;
         else if (stat_rd) armed <= 1'b0;

         if (done) begin
            done_flag <= 1'b1;
            if (unread && !rx_rd) begin
               ovr_flag <= 1'b1;
            end else begin
               rx_data <= rx_word;
               unread  <= 1'b1;
            end
         end else begin
            if (rx_rd) unread <= 1'b0;
            if (clr) begin
               done_flag <= 1'b0;
               ovr_flag  <= 1'b0;
            end
         end
      end
   end
endmodule

// File: rtl/spi_xchg_engine.sv
module spi_xchg_engine #(
   parameter int DATA_W      = 8,
   parameter int SEL_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_en,
   input  logic              cpol,
   input  logic              cpha,
   input  logic              sample_stb,
   input  logic              shift_stb,
   input  logic              sck_in,
   input  logic              ssel_n_in,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_load,
   output logic              tx_ready,
   input  logic [SEL_W-1:0]  sel_pattern,
   output logic [SEL_W-1:0]  sel_out,
   output logic              xfer_active,
   input  logic              sdi,
   output logic              sdo,
   output logic              sdo_en,
   output logic [DATA_W-1:0] rx_data,
   input  logic              rx_rd,
   input  logic              stat_rd,
   output logic              done_flag,
   output logic              ovr_flag
);
   generate
      if (DATA_W < 2) begin : g_bad_w
         $error("DATA_W must be at least 2");
      end
      if (SEL_W < 1) begin : g_bad_s
         $error("SEL_W must be at least 1");
      end
   endgenerate

   logic slv_sel, slv_sample, slv_shift;
   logic sh_busy, sh_done, start, slv_load, load;
   logic sample_p, shift_p, abort;
   logic [DATA_W-1:0] rx_word;

   spi_xchg_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk, .rst_n, .cpol, .cpha, .sck_in, .ssel_n_in,
      .selected(slv_sel), .sample_p(slv_sample), .shift_p(slv_shift)
   );

   assign tx_ready = ~xfer_active & ~sh_busy;
   assign start    = master_en  & tx_load & tx_ready;
   assign slv_load = ~master_en & tx_load & tx_ready;
   assign load     = start | slv_load;
   assign sample_p = master_en ? (sample_stb & xfer_active) : slv_sample;
   assign shift_p  = master_en ? (shift_stb  & xfer_active) : slv_shift;
   assign abort    = ~master_en & ~slv_sel;
   assign sdo_en   = master_en ? xfer_active : slv_sel;

   spi_xchg_shifter #(.DATA_W(DATA_W)) u_shift (
      .clk, .rst_n, .load, .load_val(tx_data), .sample_p, .shift_p, .abort,
      .sdi, .sdo, .busy(sh_busy), .done(sh_done), .rx_word
   );

   spi_xchg_status #(.DATA_W(DATA_W)) u_stat (
      .clk, .rst_n, .done(sh_done), .rx_word, .rx_rd, .stat_rd,
      .rx_data, .done_flag, .ovr_flag
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xfer_active <= 1'b0;
         sel_out     <= '1;
      end else if (start) begin
         xfer_active <= 1'b1;
         sel_out     <= sel_pattern;
      end else if (xfer_active && sh_done) begin
         xfer_active <= 1'b0;
         sel_out     <= '1;
      end
   end
endmodule

// File: rtl/spi_xchg_engine_chk.sv
module spi_xchg_engine_chk #(
   parameter int DATA_W = 8,
   parameter int SEL_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_en,
   input logic              tx_ready,
   input logic [SEL_W-1:0]  sel_pattern,
   input logic [SEL_W-1:0]  sel_out,
   input logic              xfer_active,
   input logic              sdo_en,
   input logic [DATA_W-1:0] rx_data,
   input logic              stat_rd,
   input logic              done_flag,
   input logic              ovr_flag
);
   a_r5_sel_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(xfer_active) |-> sel_out == $past(sel_pattern));

   a_r5_sel_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !xfer_active |-> sel_out == {SEL_W{1'b1}});

   a_r2_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_active |-> !tx_ready);

   a_r4_ovr_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> done_flag);

   a_r4_keep_unread: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovr_flag) |-> $stable(rx_data));

   a_r7_clear_on_stat: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(done_flag) |-> $past(stat_rd));

   a_r8_master_idle_off: assert property (@(posedge clk) disable iff (!rst_n)
      (master_en && !xfer_active) |-> !sdo_en);
endmodule

bind spi_xchg_engine spi_xchg_engine_chk #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (.*);

// File: tb/spi_xchg_engine_tb.sv
module spi_xchg_engine_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic master_en = 1'b1, cpol = 1'b0, cpha = 1'b0;
   logic sample_stb = 1'b0, shift_stb = 1'b0, sck_in = 1'b0, ssel_n_in = 1'b1;
   logic [7:0] tx_data = 8'h00, sel_pattern = 8'hFF;
   logic tx_load = 1'b0, sdi = 1'b0, rx_rd = 1'b0, stat_rd = 1'b0;
   logic tx_ready, xfer_active, sdo, sdo_en, done_flag, ovr_flag;
   logic [7:0] sel_out, rx_data;

   int n_tests = 0;
   int n_fail  = 0;
   localparam int HALF = 6;

   always #10 clk = ~clk;

   spi_xchg_engine u_dut (
      .clk, .rst_n, .master_en, .cpol, .cpha, .sample_stb, .shift_stb,
      .sck_in, .ssel_n_in, .tx_data, .tx_load, .tx_ready, .sel_pattern,
      .sel_out, .xfer_active, .sdi, .sdo, .sdo_en, .rx_data, .rx_rd,
      .stat_rd, .done_flag, .ovr_flag
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk); s = 1'b1;
      @(negedge clk); s = 1'b0;
   endtask

   task automatic clear_flags();
      pulse(rx_rd);
      pulse(stat_rd);
   endtask

   task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rx,
                              input logic [7:0] pat, input bit disturb);
      int sdo_bad = 0;
      tx_data = tx; sel_pattern = pat;
      pulse(tx_load);
      chk(xfer_active == 1'b1, "R3 start", xfer_active, 1);
      chk(sel_out == pat, "R5 latch", sel_out, pat);
      chk(sdo_en == 1'b1, "R8 master on", sdo_en, 1);
      for (int i = 0; i < 8; i++) begin
         if (sdo != tx[7-i]) sdo_bad++;
         sdi = rx[7-i];
         if (disturb && i == 2) begin
            sel_pattern = 8'h00;
            chk(tx_ready == 1'b0, "R2 busy", tx_ready, 0);
            tx_data = 8'h00;
            pulse(tx_load);
            chk(sel_out == pat, "R5 hold", sel_out, pat);
         end
         pulse(sample_stb);
         if (i < 7) pulse(shift_stb);
      end
      chk(sdo_bad == 0, "R1 master sdo", sdo_bad, 0);
      chk(xfer_active == 1'b0, "R3 end", xfer_active, 0);
      chk(done_flag == 1'b1, "R3 done", done_flag, 1);
      chk(sel_out == 8'hFF, "R5 idle", sel_out, 8'hFF);
      chk(sdo_en == 1'b0, "R8 master off", sdo_en, 0);
   endtask

   task automatic t_reset();
      chk(tx_ready == 1'b1, "R2 reset ready", tx_ready, 1);
      chk(done_flag == 1'b0 && ovr_flag == 1'b0, "R7 reset flags", {done_flag, ovr_flag}, 0);
      chk(sel_out == 8'hFF, "R5 reset sel", sel_out, 8'hFF);
      chk(sdo_en == 1'b0, "R8 reset oe", sdo_en, 0);
   endtask

   task automatic t_master_basic();
      master_xfer(8'hA5, 8'h3C, 8'hFE, 1'b1);
      chk(rx_data == 8'h3C, "R1 R3 master rx", rx_data, 8'h3C);
   endtask

   task automatic t_flag_clear();
      pulse(stat_rd);
      chk(done_flag == 1'b1, "R7 stat alone", done_flag, 1);
      pulse(rx_rd);
      chk(done_flag == 1'b1, "R7 read alone", done_flag, 1);
      pulse(stat_rd);
      chk(done_flag == 1'b0, "R7 cleared", done_flag, 0);
   endtask

   task automatic t_overrun();
      master_xfer(8'h81, 8'h7E, 8'hBF, 1'b0);
      chk(ovr_flag == 1'b0, "R4 no ovr", ovr_flag, 0);
      master_xfer(8'h18, 8'h11, 8'h7F, 1'b0);
      chk(ovr_flag == 1'b1, "R4 ovr set", ovr_flag, 1);
      chk(rx_data == 8'h7E, "R4 keep old", rx_data, 8'h7E);
      clear_flags();
      chk(ovr_flag == 1'b0 && done_flag == 1'b0, "R7 clear both", {done_flag, ovr_flag}, 0);
   endtask

   task automatic t_slave(input logic pol, input logic pha, input logic [7:0] tx, input logic [7:0] rx);
      int sdo_bad = 0;
      master_en = 1'b0; cpol = pol; cpha = pha; sck_in = pol;
      tx_data = tx;
      pulse(tx_load);
      repeat (4) @(negedge clk);
      chk(sdo_en == 1'b0, "R8 slave unselected", sdo_en, 0);
      ssel_n_in = 1'b0;
      repeat (5) @(negedge clk);
      chk(sdo_en == 1'b1, "R8 slave selected", sdo_en, 1);
      for (int i = 0; i < 8; i++) begin
         if (!pha) begin
            if (sdo != tx[7-i]) sdo_bad++;
            sdi = rx[7-i];
            sck_in = ~pol;
            repeat (HALF) @(negedge clk);
            if (i == 3) begin
               pulse(shift_stb);
               pulse(sample_stb);
            end
            sck_in = pol;
            repeat (HALF) @(negedge clk);
         end else begin
            sck_in = ~pol;
            repeat (HALF) @(negedge clk);
            if (sdo != tx[7-i]) sdo_bad++;
            sdi = rx[7-i];
            if (i == 3) begin
               pulse(shift_stb);
               pulse(sample_stb);
            end
            sck_in = pol;
            repeat (HALF) @(negedge clk);
         end
         if (i == 4) chk(tx_ready == 1'b0, "R2 slave busy", tx_ready, 0);
      end
      chk(sdo_bad == 0, "R1 R6 slave sdo", sdo_bad, 0);
      chk(done_flag == 1'b1, "R6 slave done", done_flag, 1);
      chk(rx_data == rx, "R6 slave rx", rx_data, rx);
      chk(sel_out == 8'hFF, "R5 slave sel idle", sel_out, 8'hFF);
      ssel_n_in = 1'b1;
      repeat (5) @(negedge clk);
      clear_flags();
   endtask

   initial begin
      fork
         begin
            repeat (3) @(negedge clk);
            rst_n = 1'b1;
            @(negedge clk);
            t_reset();
            t_master_basic();
            t_flag_clear();
            t_overrun();
            t_slave(1'b0, 1'b0, 8'hC3, 8'h5A);
            t_slave(1'b1, 1'b1, 8'h96, 8'h69);
         end
         begin
            repeat (100000) @(posedge clk);
            chk(1'b0, "watchdog", 0, 1);
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule